// File: doc/BRIEF.md
# Byte Parity and Byte-Order Datapath Stage

This stage sits on a 36-bit word path in which every word is four 9-bit bytes, and the top bit of each byte is its parity bit. It has two independent registered lanes. The ingress lane can fill in the parity bit of every byte from that byte's lower eight bits. It can also reverse the order of the four bytes. The egress lane checks the parity of every byte of a word that passes through it. It reports a per-byte error vector and one active-low summary flag.

Parity polarity is shared by both lanes. Odd is the default and a configuration input selects even. The ingress lane runs generation first and reversal second, so a generated parity bit always travels with the byte it covers. The egress check always uses the polarity configured at that moment, whether or not the word had parity generated on its way in. Each lane has one valid input and one valid output, with exactly one cycle of latency.

Top module: `byte_parity_endian`

## Requirements
- R1: While rst_ni is low, ing_valid_o and egr_valid_o are 0, ing_data_o, egr_data_o and lane_err_o are all zero, and par_err_no is 1.
- R2: ing_valid_o equals ing_valid_i of the previous clock, and egr_valid_o equals egr_valid_i of the previous clock.
- R3: With cfg_gen_en_i at 0, every bit of an accepted word reaches ing_data_o unchanged, apart from the byte placement given by R6. Byte k occupies bits [9k+8:9k].
- R4: With cfg_gen_en_i at 1 and cfg_even_i at 0, bit 8 of each byte is replaced so that the 9-bit byte holds an odd number of ones. Bits 7:0 are kept.
- R5: With cfg_gen_en_i at 1 and cfg_even_i at 1, bit 8 of each byte is replaced so that the 9-bit byte holds an even number of ones.
- R6: With cfg_swap_i at 1, output byte k is the byte from input position 3-k, moved as a whole 9-bit unit after parity generation. With cfg_swap_i at 0, byte positions are kept.
- R7: For each accepted egress word, egr_data_o equals the input word unchanged. lane_err_o[k] is 1 exactly when byte k has an even count of ones under odd polarity (cfg_even_i=0), or an odd count under even polarity (cfg_even_i=1).
- R8: par_err_no is 0 exactly when egr_valid_o is 1 and at least one bit of lane_err_o is 1. In every other cycle it is 1, and lane_err_o is zero whenever egr_valid_o is 0.
- R9: When a lane's valid input is 0, that lane's data output keeps its previous value on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_gen_en_i | input | 1 | Enable parity generation on the ingress lane |
| cfg_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_swap_i | input | 1 | Reverse the byte order on the ingress lane |
| ing_valid_i | input | 1 | Ingress word valid |
| ing_data_i | input | 36 | Ingress word |
| ing_valid_o | output | 1 | Processed ingress word valid |
| ing_data_o | output | 36 | Processed ingress word |
| egr_valid_i | input | 1 | Egress word valid |
| egr_data_i | input | 36 | Egress word to check |
| egr_valid_o | output | 1 | Checked word valid |
| egr_data_o | output | 36 | Checked word, unchanged |
| lane_err_o | output | 4 | Per-byte parity error, bit k covers byte k |
| par_err_no | output | 1 | Summary parity error, active low |

## Verification
Parity generation and byte reversal can act on the same ingress word in the same cycle. In that case each generated bit must land in the swapped position of the byte it covers. The bench provokes this by enabling both functions on words whose bytes have different one-counts, and it judges the result against a model that computes parity first and places bytes second. The egress check can also fall in the same cycle as a polarity change that affects ingress generation. Both lanes are therefore driven on every cycle with random polarity, and each lane's output is compared against the polarity that was set when its word was accepted.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
  typedef enum logic {
    PAR_ODD  = 1'b0,
    PAR_EVEN = 1'b1
  } par_pol_e;
endpackage

// File: rtl/bpe_lane_gen.sv
module bpe_lane_gen
  import bpe_pkg::*;
#(
  parameter int unsigned LANE_W = 9
) (
  input  logic [LANE_W-1:0] lane_i,
  input  logic              gen_en_i,
  input  par_pol_e          pol_i,
  output logic [LANE_W-1:0] lane_o
);
  localparam int unsigned PAY_W = LANE_W - 1;

  logic par_bit;
  // odd: bit set when payload has even ones
  assign par_bit = (^lane_i[PAY_W-1:0]) ^ (pol_i == PAR_ODD);
  assign lane_o  = gen_en_i ? {par_bit, lane_i[PAY_W-1:0]} : lane_i;
endmodule

// File: rtl/bpe_lane_chk.sv
module bpe_lane_chk
  import bpe_pkg::*;
#(
  parameter int unsigned LANE_W = 9
) (
  input  logic [LANE_W-1:0] lane_i,
  input  par_pol_e          pol_i,
  output logic              err_o
);
  // odd expects reduction-xor 1, even expects 0
  assign err_o = (^lane_i) ^ (pol_i == PAR_ODD);
endmodule

// File: rtl/bpe_ingress.sv
module bpe_ingress
  import bpe_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    gen_en_i,
  input  par_pol_e                pol_i,
  input  logic                    swap_i,
  input  logic                    valid_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic                    valid_o,
  output logic [LANES*LANE_W-1:0] data_o
);
  localparam int unsigned WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] gen_word;
  logic [WORD_W-1:0] ord_word;
  logic [WORD_W-1:0] data_q;
  logic              valid_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bpe_lane_gen #(.LANE_W(LANE_W)) u_gen (
      .lane_i   (data_i[k*LANE_W +: LANE_W]),
      .gen_en_i (gen_en_i),
      .pol_i    (pol_i),
      .lane_o   (gen_word[k*LANE_W +: LANE_W])
    );
    // reversal after generation keeps parity with its byte
    assign ord_word[k*LANE_W +: LANE_W] = swap_i ? gen_word[(LANES-1-k)*LANE_W +: LANE_W]
                                                 : gen_word[k*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) data_q <= ord_word;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  a_r2_ing_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));
  a_r9_ing_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    a_r4_r5_gen_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && gen_en_i) |=> ((^data_o[k*LANE_W +: LANE_W]) == $past(pol_i == PAR_ODD)));
  end
endmodule

// File: rtl/bpe_egress.sv
module bpe_egress
  import bpe_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  par_pol_e                pol_i,
  input  logic                    valid_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic                    valid_o,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic [LANES-1:0]        lane_err_o,
  output logic                    err_no
);
  localparam int unsigned WORD_W = LANES * LANE_W;

  logic [LANES-1:0]  err_c;
  logic [LANES-1:0]  err_q;
  logic [WORD_W-1:0] data_q;
  logic              valid_q;
  logic              err_nq;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bpe_lane_chk #(.LANE_W(LANE_W)) u_chk (
      .lane_i (data_i[k*LANE_W +: LANE_W]),
      .pol_i  (pol_i),
      .err_o  (err_c[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      err_q   <= '0;
      err_nq  <= 1'b1;
    end else begin
      valid_q <= valid_i;
      if (valid_i) data_q <= data_i;
      err_q   <= valid_i ? err_c : '0;
      err_nq  <= ~(valid_i & (|err_c));
    end
  end

  assign valid_o    = valid_q;
  assign data_o     = data_q;
  assign lane_err_o = err_q;
  assign err_no     = err_nq;

  a_r7_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (data_o == $past(data_i)));
  a_r8_flag_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (|lane_err_o)) |-> !err_no);
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (err_no && (lane_err_o == '0)));
  a_r8_flag_needs_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_no |-> (|lane_err_o));
  a_r9_egr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
endmodule

// File: rtl/byte_parity_endian.sv
module byte_parity_endian
  import bpe_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_gen_en_i,
  input  logic              cfg_even_i,
  input  logic              cfg_swap_i,
  input  logic              ing_valid_i,
  input  logic [WORD_W-1:0] ing_data_i,
  output logic              ing_valid_o,
  output logic [WORD_W-1:0] ing_data_o,
  input  logic              egr_valid_i,
  input  logic [WORD_W-1:0] egr_data_i,
  output logic              egr_valid_o,
  output logic [WORD_W-1:0] egr_data_o,
  output logic [LANES-1:0]  lane_err_o,
  output logic              par_err_no
);
  par_pol_e pol;
  assign pol = cfg_even_i ? PAR_EVEN : PAR_ODD;

  bpe_ingress #(.LANES(LANES), .LANE_W(LANE_W)) u_ing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gen_en_i (cfg_gen_en_i),
    .pol_i    (pol),
    .swap_i   (cfg_swap_i),
    .valid_i  (ing_valid_i),
    .data_i   (ing_data_i),
    .valid_o  (ing_valid_o),
    .data_o   (ing_data_o)
  );

  bpe_egress #(.LANES(LANES), .LANE_W(LANE_W)) u_egr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pol_i      (pol),
    .valid_i    (egr_valid_i),
    .data_i     (egr_data_i),
    .valid_o    (egr_valid_o),
    .data_o     (egr_data_o),
    .lane_err_o (lane_err_o),
    .err_no     (par_err_no)
  );
endmodule

// File: tb/tb_byte_parity_endian.sv
module tb_byte_parity_endian;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_gen_en_i = 1'b0, cfg_even_i = 1'b0, cfg_swap_i = 1'b0;
  logic        ing_valid_i = 1'b0, egr_valid_i = 1'b0;
  logic [35:0] ing_data_i = '0, egr_data_i = '0;
  logic        ing_valid_o, egr_valid_o, par_err_no;
  logic [35:0] ing_data_o, egr_data_o;
  logic [3:0]  lane_err_o;

  int n_chk = 0;
  int n_bad = 0;

  // expected state
  logic        x_ing_v = 1'b0, x_egr_v = 1'b0, x_flag_n = 1'b1;
  logic [35:0] x_ing_d = '0, x_egr_d = '0;
  logic [3:0]  x_err = '0;

  always #10 clk_i = ~clk_i;

  byte_parity_endian dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_gen_en_i(cfg_gen_en_i), .cfg_even_i(cfg_even_i), .cfg_swap_i(cfg_swap_i),
    .ing_valid_i(ing_valid_i), .ing_data_i(ing_data_i),
    .ing_valid_o(ing_valid_o), .ing_data_o(ing_data_o),
    .egr_valid_i(egr_valid_i), .egr_data_i(egr_data_i),
    .egr_valid_o(egr_valid_o), .egr_data_o(egr_data_o),
    .lane_err_o(lane_err_o), .par_err_no(par_err_no)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [35:0] ref_ing(input logic [35:0] w, input logic gen,
                                          input logic even, input logic swap);
    logic [35:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      logic [8:0] b = w[9*k +: 9];
      int ones = $countones(b[7:0]);
      int pos = swap ? 3 - k : k;
      if (gen) b[8] = even ? (ones % 2 == 1) : (ones % 2 == 0);
      r[9*pos +: 9] = b;
    end
    return r;
  endfunction

  function automatic logic [3:0] ref_err(input logic [35:0] w, input logic even);
    logic [3:0] e;
    for (int k = 0; k < 4; k++) begin
      int ones = $countones(w[9*k +: 9]);
      e[k] = even ? (ones % 2 == 1) : (ones % 2 == 0);
    end
    return e;
  endfunction

  // drive at negedge, update model, compare after the next posedge
  task automatic step(input logic iv, input logic [35:0] id, input logic ev,
                      input logic [35:0] ed, input logic gen, input logic even,
                      input logic swap, input string tag);
    @(negedge clk_i);
    ing_valid_i = iv; ing_data_i = id; egr_valid_i = ev; egr_data_i = ed;
    cfg_gen_en_i = gen; cfg_even_i = even; cfg_swap_i = swap;
    x_ing_v = iv;
    if (iv) x_ing_d = ref_ing(id, gen, even, swap);
    x_egr_v = ev;
    if (ev) x_egr_d = ed;
    x_err = ev ? ref_err(ed, even) : 4'h0;
    x_flag_n = !(ev && (x_err != 0));
    @(posedge clk_i); #2;
    check({"R2 ing_valid ", tag}, {35'd0, ing_valid_o}, {35'd0, x_ing_v});
    check({"R3 R4 R5 R6 R9 ing_data ", tag}, ing_data_o, x_ing_d);
    check({"R2 egr_valid ", tag}, {35'd0, egr_valid_o}, {35'd0, x_egr_v});
    check({"R7 R9 egr_data ", tag}, egr_data_o, x_egr_d);
    check({"R7 lane_err ", tag}, {32'd0, lane_err_o}, {32'd0, x_err});
    check({"R8 par_err_n ", tag}, {35'd0, par_err_no}, {35'd0, x_flag_n});
  endtask

  function automatic logic [35:0] rnd36();
    logic [63:0] t = {$urandom(), $urandom()};
    return t[35:0];
  endfunction

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [35:0] w;
    repeat (2) @(posedge clk_i);
    #2;
    check("R1 ing_valid", {35'd0, ing_valid_o}, 36'd0);
    check("R1 ing_data", ing_data_o, 36'd0);
    check("R1 egr_valid", {35'd0, egr_valid_o}, 36'd0);
    check("R1 egr_data", egr_data_o, 36'd0);
    check("R1 lane_err", {32'd0, lane_err_o}, 36'd0);
    check("R1 par_err_n", {35'd0, par_err_no}, 36'd1);
    @(negedge clk_i); rst_ni = 1'b1;

    // R3 passthrough, distinct byte values
    w = {9'h1a5, 9'h0c3, 9'h17e, 9'h001};
    step(1, w, 0, '0, 0, 0, 0, "R3 plain");
    // R6 reversal alone
    step(1, w, 0, '0, 0, 0, 1, "R6 swap");
    // R4 odd gen, R5 even gen, on zeros and ones
    step(1, 36'h0, 0, '0, 1, 0, 0, "R4 zeros");
    step(1, 36'hfffffffff, 0, '0, 1, 0, 0, "R4 ones");
    step(1, 36'h0, 0, '0, 1, 1, 0, "R5 zeros");
    step(1, {9'h003, 9'h007, 9'h1ff, 9'h080}, 0, '0, 1, 1, 0, "R5 mixed");
    // gen and swap in the same word
    step(1, {9'h003, 9'h007, 9'h0ff, 9'h180}, 0, '0, 1, 0, 1, "R4 R6 combo");
    step(1, {9'h103, 9'h007, 9'h0fe, 9'h080}, 0, '0, 1, 1, 1, "R5 R6 combo");
    // R9 hold on both lanes
    step(0, rnd36(), 0, rnd36(), 1, 1, 1, "R9 hold");
    // R7/R8 clean odd word then single-lane errors
    w = ref_ing(36'h0, 1, 0, 0);
    step(0, '0, 1, w, 0, 0, 0, "R8 clean odd");
    for (int k = 0; k < 4; k++) step(0, '0, 1, w ^ (36'd1 << (9*k)), 0, 0, 0, "R7 lane flip");
    // same word judged under even polarity: all lanes fail
    step(0, '0, 1, w, 0, 1, 0, "R7 R8 polarity");
    step(0, '0, 0, '0, 0, 0, 0, "R8 idle");
    // random, both lanes every cycle
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r = $urandom();
      step(r[0], rnd36(), r[1], rnd36(), r[2], r[3], r[4], "random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule